// File: doc/BRIEF.md
# Addressed Twelve-Channel DAC Code Register Bank

This block is a write-only two-wire serial slave that holds the 8-bit codes for twelve external resistor-ladder converters. It samples the clock and data lines with the system clock, cleans them up, finds the frame boundaries, and shifts in bytes most significant bit first. It answers each accepted byte by pulling the data line low for one bit time. Each channel code N sets a ladder output of N/256 of the reference above the low rail. Code 00 gives the low rail and FF gives 255/256 of the reference.

A frame carries the device address with the direction bit, then a command byte, then one or more data bytes. The low nibble of the command picks one of three modes: one channel, one value broadcast to every channel, or a sequential fill that steps through the channels and wraps around. Three strap inputs set the low address bits, so up to eight banks can share one bus. Every channel register has its own one-cycle update strobe.

Top module: `i2c_dac_bank`

## Requirements
- R1: After reset all twelve channel registers read 00, every update strobe is low and the data line is released (sda_oe_o = 0).
- R2: A first byte whose upper seven bits equal 1001 followed by strap_i[2:0], and whose last bit (direction) is 0, is acknowledged by driving sda_oe_o high during the ninth clock. Any other first byte, including one with direction bit 1, is not acknowledged, and every later byte up to the next START is neither acknowledged nor stored.
- R3: Only bits [3:0] of the command byte are decoded; bits [7:4] have no effect.
- R4: Command nibble 0 writes each following data byte to all twelve channels at once.
- R5: Command nibble k in 1..12 writes each following data byte to channel k only (channel 1 is the lowest field of chan_o).
- R6: Command nibble 15 writes successive data bytes to channels 1, 2, … 12, then wraps to channel 1 and continues until the frame ends.
- R7: Command nibbles 13 and 14 are not acknowledged, and the data bytes that follow are neither acknowledged nor stored.
- R8: Each stored data byte raises upd_o for exactly one clock, on exactly the channels written, in the clock where the new code first appears on chan_o; a channel code never changes without its strobe.
- R9: A repeated START at any point restarts the frame, so the next byte is taken as an address.
- R10: A STOP ends the frame and releases the data line; bytes after it are ignored until a START.
- R11: A pulse on SCL shorter than FILT_LEN system clocks does not clock a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 3 | Low three address bits |
| sda_oe_o | output | 1 | Pull data line low when 1 (acknowledge) |
| chan_o | output | 96 | Twelve 8-bit channel codes, channel 1 in bits [7:0] |
| upd_o | output | 12 | Per-channel update strobe, channel 1 in bit 0 |

## Verification
The bench sends frames in each command mode: single channel with a clean and a noisy upper nibble, broadcast followed by a single overwrite, and a sequential fill long enough to wrap past channel 12. These show whether the decoder routes each byte to the correct register set. Frames with a foreign strap address, a read direction bit and the two unused command codes check that a refused frame acknowledges nothing and stores nothing. A repeated START between two writes and a short spike on SCL inside a byte check frame restart and input filtering. Update strobes are counted per channel and compared with the number of writes the model expects.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam logic [3:0] ADDR_HI = 4'b1001;

  typedef enum logic [1:0] {
    KIND_ADDR = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_DATA = 2'd2
  } byte_kind_e;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_ALL  = 2'd2,
    MODE_SEQ  = 2'd3
  } wr_mode_e;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_o
);
  logic [1:0]          meta_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      meta_q <= {meta_q[0], pin_i};
      hist_q <= {hist_q[FILT_LEN-2:0], meta_q[1]};
      if (&hist_q)       out_q <= 1'b1;
      else if (~|hist_q) out_q <= 1'b0;
    end
  end

  assign pin_o = out_q;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import dac_bank_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       ack_ok_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output byte_kind_e kind_o,
  output logic       sda_oe_o
);
  localparam int BCW = 4;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(7);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(8);

  logic           scl_q, sda_q;
  logic           active_q, in_ack_q, vld_q, ack_want_q, sda_oe_q;
  logic [BCW-1:0] bit_cnt_q;
  logic [1:0]     byte_idx_q;
  logic [7:0]     shreg_q;

  logic scl_rise_w, scl_fall_w, start_w, stop_w, addr_ok_w;
  assign scl_rise_w = scl_i & ~scl_q;
  assign scl_fall_w = ~scl_i & scl_q;
  assign start_w    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_w     = scl_i & scl_q & ~sda_q & sda_i;
  assign addr_ok_w  = (shreg_q[7:1] == {ADDR_HI, strap_i}) && !shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      in_ack_q   <= 1'b0;
      vld_q      <= 1'b0;
      ack_want_q <= 1'b0;
      sda_oe_q   <= 1'b0;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
    end else begin
      vld_q <= 1'b0;
      if (start_w) begin
        active_q   <= 1'b1;
        in_ack_q   <= 1'b0;
        sda_oe_q   <= 1'b0;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
      end else if (stop_w) begin
        active_q  <= 1'b0;
        in_ack_q  <= 1'b0;
        sda_oe_q  <= 1'b0;
        bit_cnt_q <= '0;
      end else if (active_q) begin
        if (scl_rise_w && bit_cnt_q != ACK_SLOT) begin
          shreg_q   <= {shreg_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + BCW'(1);
          if (bit_cnt_q == LAST_BIT) vld_q <= 1'b1;
        end
        if (vld_q) ack_want_q <= (byte_idx_q == 2'd0) ? addr_ok_w : ack_ok_i;
        if (scl_fall_w && bit_cnt_q == ACK_SLOT) begin
          if (!in_ack_q) begin
            in_ack_q <= 1'b1;
            sda_oe_q <= ack_want_q;
          end else begin
            in_ack_q  <= 1'b0;
            sda_oe_q  <= 1'b0;
            bit_cnt_q <= '0;
            if (!ack_want_q)              active_q   <= 1'b0;
            else if (byte_idx_q != 2'd2)  byte_idx_q <= byte_idx_q + 2'd1;
          end
        end
      end
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = shreg_q;
  assign kind_o     = (byte_idx_q == 2'd0) ? KIND_ADDR :
                      (byte_idx_q == 2'd1) ? KIND_CMD : KIND_DATA;
  assign sda_oe_o   = sda_oe_q;

  p_oe_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_q |-> active_q);
  p_ack_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> $past(scl_fall_w));
  p_stop_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_w |=> !sda_oe_q && !active_q);
endmodule

// File: rtl/dac_chan_ctrl.sv
module dac_chan_ctrl
  import dac_bank_pkg::*;
#(
  parameter int N_CH = 12,
  parameter int DW   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  byte_kind_e       kind_i,
  output logic             ack_ok_o,
  output logic [N_CH*DW-1:0] chan_o,
  output logic [N_CH-1:0]  upd_o
);
  localparam int CW = $clog2(N_CH);
  localparam logic [3:0] SEQ_CODE = 4'hF;
  localparam logic [CW-1:0] LAST_CH = CW'(N_CH - 1);

  wr_mode_e         mode_q;
  logic [CW-1:0]    ptr_q;
  logic [DW-1:0]    chan_q [N_CH];
  logic [N_CH-1:0]  upd_q, we_w;
  logic [3:0]       code_w;
  logic             code_one_w, code_ok_w, data_w;

  assign code_w     = byte_i[3:0];
  assign code_one_w = (code_w != 4'd0) && (int'(code_w) <= N_CH);
  assign code_ok_w  = (code_w == 4'd0) || code_one_w || (code_w == SEQ_CODE);
  assign data_w     = byte_vld_i && (kind_i == KIND_DATA);

  always_comb begin
    case (kind_i)
      KIND_CMD:  ack_ok_o = code_ok_w;
      KIND_DATA: ack_ok_o = (mode_q != MODE_NONE);
      default:   ack_ok_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_NONE;
      ptr_q  <= '0;
    end else if (byte_vld_i && kind_i == KIND_CMD) begin
      ptr_q <= '0;
      if (code_w == 4'd0)          mode_q <= MODE_ALL;
      else if (code_w == SEQ_CODE) mode_q <= MODE_SEQ;
      else if (code_one_w) begin
        mode_q <= MODE_ONE;
        ptr_q  <= CW'(code_w - 4'd1);
      end else                     mode_q <= MODE_NONE;
    end else if (data_w && mode_q == MODE_SEQ) begin
      ptr_q <= (ptr_q == LAST_CH) ? '0 : ptr_q + CW'(1);
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign we_w[i] = data_w && ((mode_q == MODE_ALL) ||
                     ((mode_q == MODE_ONE || mode_q == MODE_SEQ) && ptr_q == CW'(i)));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chan_q[i] <= '0;
        upd_q[i]  <= 1'b0;
      end else begin
        upd_q[i] <= we_w[i];
        if (we_w[i]) chan_q[i] <= byte_i;
      end
    end

    assign chan_o[i*DW +: DW] = chan_q[i];

    p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (chan_q[i] != $past(chan_q[i])) |-> upd_q[i]);
  end

  assign upd_o = upd_q;

  p_upd_shape_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_q != '0) |-> ($countones(upd_q) == 1 || &upd_q));
  p_no_write_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_q != '0) |-> $past(mode_q != MODE_NONE));
endmodule

// File: rtl/i2c_dac_bank.sv
module i2c_dac_bank
  import dac_bank_pkg::*;
#(
  parameter int N_CH     = 12,
  parameter int DW       = 8,
  parameter int FILT_LEN = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [2:0]         strap_i,
  output logic               sda_oe_o,
  output logic [N_CH*DW-1:0] chan_o,
  output logic [N_CH-1:0]    upd_o
);
  logic       scl_f, sda_f, byte_vld, ack_ok;
  logic [7:0] byte_d;
  byte_kind_e kind;

  i2c_pin_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(scl_i), .pin_o(scl_f));
  i2c_pin_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(sda_i), .pin_o(sda_f));

  i2c_byte_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .strap_i(strap_i), .ack_ok_i(ack_ok), .byte_vld_o(byte_vld),
    .byte_o(byte_d), .kind_o(kind), .sda_oe_o(sda_oe_o));

  dac_chan_ctrl #(.N_CH(N_CH), .DW(DW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .kind_i(kind), .ack_ok_o(ack_ok), .chan_o(chan_o), .upd_o(upd_o));
endmodule

// File: tb/i2c_dac_bank_tb.sv
module i2c_dac_bank_tb;
  localparam int N_CH = 12;
  localparam int Q    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe;
  logic [N_CH*8-1:0] chan;
  logic [N_CH-1:0] upd;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_dac_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .chan_o(chan), .upd_o(upd));

  int n_chk = 0, n_err = 0;
  bit chk_en = 1'b0;
  string cur_req = "R1";

  int exp_reg [N_CH];
  int exp_cnt [N_CH];
  int got_cnt [N_CH];
  bit m_active = 1'b0;
  int m_idx = 0, m_mode = 0, m_ptr = 0; // mode: 0 none 1 one 2 all 3 seq

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) for (int i = 0; i < N_CH; i++) if (upd[i]) got_cnt[i]++;
    if (chk_en)
      for (int i = 0; i < N_CH; i++)
        chk(chan[i*8 +: 8] == 8'(exp_reg[i]), cur_req, $sformatf("ch%0d", i + 1),
            chan[i*8 +: 8], exp_reg[i]);
  end

  task automatic m_write(int ch, int v);
    exp_reg[ch] = v;
    exp_cnt[ch]++;
  endtask

  task automatic bus_start();
    chk_en = 1'b0;
    sda_m = 1'b1; cyc(Q);
    scl_m = 1'b1; cyc(Q);
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b0; cyc(Q);
    m_active = 1'b1; m_idx = 0;
    chk_en = 1'b1;
  endtask

  task automatic bus_stop();
    chk_en = 1'b0;
    sda_m = 1'b0; cyc(Q);
    scl_m = 1'b1; cyc(Q);
    sda_m = 1'b1; cyc(2 * Q);
    m_active = 1'b0;
    chk_en = 1'b1;
    chk(sda_oe == 1'b0, "R10", "sda released after stop", sda_oe, 0);
  endtask

  task automatic send_bit(bit b, bit glitch);
    sda_m = b;
    if (glitch) begin
      cyc(2); scl_m = 1'b1; cyc(1); scl_m = 1'b0; cyc(Q - 3);
    end else cyc(Q);
    scl_m = 1'b1; cyc(2 * Q);
    scl_m = 1'b0; cyc(Q);
  endtask

  task automatic send_byte(logic [7:0] b, string req, bit glitch = 1'b0);
    bit exp_ack;
    int code;
    chk_en = 1'b0;
    for (int k = 7; k >= 0; k--) send_bit(b[k], glitch && k == 4);
    exp_ack = 1'b0;
    if (m_active) begin
      if (m_idx == 0) exp_ack = (b[7:1] == {4'b1001, strap}) && !b[0];
      else if (m_idx == 1) begin
        code = int'(b[3:0]);
        exp_ack = 1'b1;
        m_ptr = 0;
        if (code == 0) m_mode = 2;
        else if (code == 15) m_mode = 3;
        else if (code <= N_CH) begin m_mode = 1; m_ptr = code - 1; end
        else begin m_mode = 0; exp_ack = 1'b0; end
      end else begin
        exp_ack = (m_mode != 0);
        if (m_mode == 2) for (int i = 0; i < N_CH; i++) m_write(i, b);
        else if (m_mode != 0) m_write(m_ptr, b);
        if (m_mode == 3) m_ptr = (m_ptr + 1) % N_CH;
      end
    end
    sda_m = 1'b1; cyc(Q);
    scl_m = 1'b1; cyc(Q);
    chk(sda_oe == exp_ack, req, $sformatf("ack byte %02h", b), sda_oe, exp_ack);
    cyc(Q);
    scl_m = 1'b0; cyc(Q);
    if (exp_ack) begin if (m_idx < 2) m_idx++; end
    else m_active = 1'b0;
    chk_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_CH; i++) begin exp_reg[i] = 0; exp_cnt[i] = 0; got_cnt[i] = 0; end
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    // R1: reset state
    chk(chan == '0, "R1", "regs after reset", 0, 0);
    chk(upd == '0, "R1", "strobes after reset", upd, 0);
    chk(sda_oe == 1'b0, "R1", "sda after reset", sda_oe, 0);
    chk_en = 1'b1;

    // R5: single channel
    cur_req = "R5";
    bus_start(); send_byte(8'h9A, "R2"); send_byte(8'h05, "R5"); send_byte(8'hA5, "R5"); bus_stop();
    // R3: upper nibble ignored
    cur_req = "R3";
    bus_start(); send_byte(8'h9A, "R2"); send_byte(8'hF3, "R3"); send_byte(8'h3C, "R3"); bus_stop();
    // R4: broadcast then single overwrite of channel 12
    cur_req = "R4";
    bus_start(); send_byte(8'h9A, "R2"); send_byte(8'h00, "R4"); send_byte(8'h77, "R4"); bus_stop();
    bus_start(); send_byte(8'h9A, "R2"); send_byte(8'h0C, "R5"); send_byte(8'hFF, "R5"); bus_stop();
    // R6: sequential fill with wrap
    cur_req = "R6";
    bus_start(); send_byte(8'h9A, "R2"); send_byte(8'h0F, "R6");
    for (int i = 0; i < 14; i++) send_byte(8'(8'h10 + i), "R6");
    bus_stop();
    chk(chan[7:0] == 8'h1C, "R6", "ch1 after wrap", chan[7:0], 8'h1C);
    chk(chan[95:88] == 8'h1B, "R6", "ch12 in fill", chan[95:88], 8'h1B);
    // R2: foreign address and read direction
    cur_req = "R2";
    bus_start(); send_byte(8'h98, "R2"); send_byte(8'h01, "R2"); send_byte(8'h55, "R2"); bus_stop();
    bus_start(); send_byte(8'h9B, "R2"); send_byte(8'h01, "R2"); send_byte(8'h55, "R2"); bus_stop();
    // R7: unused command codes
    cur_req = "R7";
    bus_start(); send_byte(8'h9A, "R2"); send_byte(8'h0D, "R7"); send_byte(8'h66, "R7"); bus_stop();
    bus_start(); send_byte(8'h9A, "R2"); send_byte(8'h2E, "R7"); send_byte(8'h66, "R7"); bus_stop();
    // R9: repeated start
    cur_req = "R9";
    bus_start(); send_byte(8'h9A, "R2"); send_byte(8'h01, "R9"); send_byte(8'h11, "R9");
    bus_start(); send_byte(8'h9A, "R9"); send_byte(8'h02, "R9"); send_byte(8'h22, "R9"); bus_stop();
    // R10: bytes after stop ignored
    cur_req = "R10";
    send_byte(8'h9A, "R10"); send_byte(8'h04, "R10");
    chk(chan[31:24] == 8'h13, "R10", "ch4 untouched after stop", chan[31:24], 8'h13);
    // R11: short SCL spike inside a byte
    cur_req = "R11";
    strap = 3'b010;
    bus_start(); send_byte(8'h94, "R11", 1'b1); send_byte(8'h06, "R11", 1'b1);
    send_byte(8'hC3, "R11", 1'b1); bus_stop();
    chk(chan[47:40] == 8'hC3, "R11", "ch6 with spikes", chan[47:40], 8'hC3);
    cyc(5);
    // R8: strobe counts per channel
    for (int i = 0; i < N_CH; i++)
      chk(got_cnt[i] == exp_cnt[i], "R8", $sformatf("strobes ch%0d", i + 1), got_cnt[i], exp_cnt[i]);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule